// File: doc/BRIEF.md
# Peripheral ROM Window Latch

This block sits on a 16-bit address, 8-bit data system bus and decodes the peripheral ROM region C100 to CFFF. For every valid read it tells the rest of the system where the byte must come from. It can come from the internal ROM image. It can come from one of the card slots, given as a one-hot slot select. It can also float, because no source drives that address. Writes into the region are flagged as discarded and select nothing.

Slots share a 2 KB expansion window at C800 to CFFF. The block keeps a small owner register for this window. The first access to a slot's own page (C100 to C7FF) while the window is free hands the window to that slot, with the slot number taken from address bits 10:8. Any access to CFFF frees the window again. The block also keeps two override switches: the internal-ROM switch and the slot-3 switch. They are set and cleared by writes to the I/O switch page, and their states are returned by status reads. Both overrides take priority over the window owner.

Select and status outputs are combinational from the present address and state. Owner and switch updates land on the clock edge that ends a valid bus cycle.

Top module: `cx_rom_window`

## Requirements
- R1: While the window is free, a valid access (read or write) to C100–C7FF claims it for slot addr[10:8]. While it is owned, accesses other than CFFF leave the owner unchanged.
- R2: A valid access to CFFF frees the window. A later read of C800–CFFF, with both switches clear, then raises sel_float.
- R3: While the slot-3 switch is set, an access to page C3 does not claim a free window.
- R4: While the internal-ROM switch is set, a read of any page C1–CF raises sel_internal and no card select, whatever the owner.
- R5: While the internal-ROM switch is clear and the slot-3 switch is set, reads of page C3 and pages C8–CF raise sel_internal.
- R6: Without an override, a read of page Cn (n = 1..7) raises sel_card bit n. A read of C8–CF raises sel_card bit <owner>, or sel_float when the window is free. At most one of all selects is high.
- R7: Writes to C006 and C007 clear and set the internal-ROM switch. Writes to C00A and C00B clear and set the slot-3 switch.
- R8: A read of C015 returns the internal-ROM switch in stat_data bit 7, and a read of C017 returns the slot-3 switch there. Bits 6:0 are zero and stat_hit is high. Otherwise stat_hit is low and stat_data is zero.
- R9: A valid write to C100–CFFF raises wr_discard and raises no select.
- R10: Reset clears both switches and frees the window.
- R11: No select is raised for addresses outside C100–CFFF or when bus_valid is low. A cycle with bus_valid low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 16 | Bus address |
| sel_internal | output | 1 | Read byte comes from the internal ROM image |
| sel_card | output | 8 | One-hot card slot select (bit 0 never used) |
| sel_float | output | 1 | Read of the window while it is free; nothing drives the bus |
| wr_discard | output | 1 | Write into C100–CFFF, dropped |
| stat_hit | output | 1 | Read hits a switch status address |
| stat_data | output | 8 | Status byte, switch state in bit 7 |

## Verification
Selects, wr_discard and status are due in the same cycle as the address, because they are combinational. The bench drives each cycle just after a falling edge and samples 1 ns later, well before the rising edge. Owner and switch changes become visible only in the cycle after the rising edge that ends the causing access. The bench's reference model therefore applies its next state only after that edge, and each latch or switch effect is checked on a follow-up read. Sweeps cover every ROM page under every switch combination, with the window free, owned by an ordinary slot and owned by slot 3.

// File: rtl/cxw_pkg.sv
package cxw_pkg;

   // high nibble of the I/O + peripheral ROM region
   localparam logic [3:0]  IO_NIBBLE     = 4'hC;
   // page inside the region that carries the soft switches
   localparam logic [3:0]  SWITCH_PAGE   = 4'h0;
   // low-byte offsets of the switch and status locations
   localparam logic [7:0]  OFS_INT_CLR   = 8'h06;
   localparam logic [7:0]  OFS_INT_SET   = 8'h07;
   localparam logic [7:0]  OFS_S3_CLR    = 8'h0A;
   localparam logic [7:0]  OFS_S3_SET    = 8'h0B;
   localparam logic [7:0]  OFS_INT_STAT  = 8'h15;
   localparam logic [7:0]  OFS_S3_STAT   = 8'h17;
   // low 12 bits of the window release location
   localparam logic [11:0] RELEASE_LOW   = 12'hFFF;
   // the slot whose page the slot-3 switch guards
   localparam int unsigned GUARDED_SLOT  = 3;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_INT   = 2'd1,
      SRC_CARD  = 2'd2,
      SRC_FLOAT = 2'd3
   } rom_src_e;

endpackage

// File: rtl/cxw_switches.sv
module cxw_switches
   import cxw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned STAT_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              int_sw,
   output logic              slot3_sw,
   output logic              stat_hit,
   output logic [DATA_W-1:0] stat_data
);

   logic in_sw_page;
   logic [7:0] ofs;

   assign in_sw_page = (bus_addr[ADDR_W-1 -: 4] == IO_NIBBLE) &&
                       (bus_addr[ADDR_W-5 -: 4] == SWITCH_PAGE);
   assign ofs = bus_addr[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_sw   <= 1'b0;
         slot3_sw <= 1'b0;
      end else if (bus_valid && bus_we && in_sw_page) begin
         case (ofs)
            OFS_INT_CLR: int_sw   <= 1'b0;
            OFS_INT_SET: int_sw   <= 1'b1;
            OFS_S3_CLR:  slot3_sw <= 1'b0;
            OFS_S3_SET:  slot3_sw <= 1'b1;
            default: ;
         endcase
      end
   end

   always_comb begin
      stat_hit  = 1'b0;
      stat_data = '0;
      if (bus_valid && !bus_we && in_sw_page) begin
         if (ofs == OFS_INT_STAT) begin
            stat_hit            = 1'b1;
            stat_data[STAT_BIT] = int_sw;
         end else if (ofs == OFS_S3_STAT) begin
            stat_hit            = 1'b1;
            stat_data[STAT_BIT] = slot3_sw;
         end
      end
   end

endmodule

// File: rtl/cxw_owner.sv
module cxw_owner
   import cxw_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_SLOTS = 8,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              slot3_sw,
   output logic              owned,
   output logic [SLOT_W-1:0] owner
);

   logic [3:0]        page;
   logic              in_io;
   logic              slot_page;
   logic              release_hit;
   logic              guarded;
   logic              claim;

   assign in_io       = (bus_addr[ADDR_W-1 -: 4] == IO_NIBBLE);
   assign page        = bus_addr[ADDR_W-5 -: 4];
   // pages 1..7 belong to individual slots
   assign slot_page   = in_io && !page[3] && (page != 4'h0);
   assign release_hit = in_io && (bus_addr[ADDR_W-5:0] == RELEASE_LOW);
   assign guarded     = slot3_sw && (page[SLOT_W-1:0] == SLOT_W'(GUARDED_SLOT));
   assign claim       = !owned && slot_page && !guarded;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owned <= 1'b0;
         owner <= '0;
      end else if (bus_valid) begin
         if (release_hit) begin
            owned <= 1'b0;
         end else if (claim) begin
            owned <= 1'b1;
            owner <= page[SLOT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/cxw_route.sv
module cxw_route
   import cxw_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_SLOTS = 8,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic                 bus_valid,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 int_sw,
   input  logic                 slot3_sw,
   input  logic                 owned,
   input  logic [SLOT_W-1:0]    owner,
   output logic                 sel_internal,
   output logic [NUM_SLOTS-1:0] sel_card,
   output logic                 sel_float,
   output logic                 wr_discard
);

   logic [3:0]        page;
   logic              in_rom;
   logic              shared_pg;
   logic              override;
   rom_src_e          src;
   logic [SLOT_W-1:0] card_num;

   assign page      = bus_addr[ADDR_W-5 -: 4];
   assign in_rom    = (bus_addr[ADDR_W-1 -: 4] == IO_NIBBLE) && (page != 4'h0);
   assign shared_pg = page[3];
   assign override  = int_sw ||
                      (slot3_sw && (shared_pg || page == 4'(GUARDED_SLOT)));

   always_comb begin
      src      = SRC_NONE;
      card_num = '0;
      if (bus_valid && !bus_we && in_rom) begin
         if (override) begin
            src = SRC_INT;
         end else if (!shared_pg) begin
            src      = SRC_CARD;
            card_num = page[SLOT_W-1:0];
         end else if (owned) begin
            src      = SRC_CARD;
            card_num = owner;
         end else begin
            src = SRC_FLOAT;
         end
      end
   end

   assign sel_internal = (src == SRC_INT);
   assign sel_float    = (src == SRC_FLOAT);
   assign wr_discard   = bus_valid && bus_we && in_rom;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_card
      assign sel_card[s] = (src == SRC_CARD) && (card_num == SLOT_W'(s));
   end

endmodule

// File: rtl/cx_rom_window.sv
module cx_rom_window
   import cxw_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned STAT_BIT  = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   output logic                 sel_internal,
   output logic [NUM_SLOTS-1:0] sel_card,
   output logic                 sel_float,
   output logic                 wr_discard,
   output logic                 stat_hit,
   output logic [DATA_W-1:0]    stat_data
);

   localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);

   if (ADDR_W != 16) begin : g_bad_addr
      $error("cx_rom_window: ADDR_W must be 16");
   end
   if (NUM_SLOTS != 8) begin : g_bad_slots
      $error("cx_rom_window: NUM_SLOTS must be 8 (one per page C0-C7)");
   end
   if (STAT_BIT >= DATA_W) begin : g_bad_stat
      $error("cx_rom_window: STAT_BIT outside the data bus");
   end

   logic              int_sw;
   logic              slot3_sw;
   logic              win_owned;
   logic [SLOT_W-1:0] win_slot;

   cxw_switches #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .STAT_BIT (STAT_BIT)
   ) u_switches (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .int_sw    (int_sw),
      .slot3_sw  (slot3_sw),
      .stat_hit  (stat_hit),
      .stat_data (stat_data)
   );

   cxw_owner #(
      .ADDR_W    (ADDR_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_owner (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .slot3_sw  (slot3_sw),
      .owned     (win_owned),
      .owner     (win_slot)
   );

   cxw_route #(
      .ADDR_W    (ADDR_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_route (
      .bus_valid    (bus_valid),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .int_sw       (int_sw),
      .slot3_sw     (slot3_sw),
      .owned        (win_owned),
      .owner        (win_slot),
      .sel_internal (sel_internal),
      .sel_card     (sel_card),
      .sel_float    (sel_float),
      .wr_discard   (wr_discard)
   );

endmodule

// File: rtl/cxw_checker.sv
module cxw_checker #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_SLOTS = 8,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_valid,
   input logic                 bus_we,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 sel_internal,
   input logic [NUM_SLOTS-1:0] sel_card,
   input logic                 sel_float,
   input logic                 wr_discard,
   input logic                 stat_hit,
   input logic [DATA_W-1:0]    stat_data,
   input logic                 int_sw,
   input logic                 slot3_sw,
   input logic                 win_owned,
   input logic [SLOT_W-1:0]    win_slot
);

   logic in_rom;
   logic slot_pg;
   assign in_rom  = (bus_addr[15:12] == 4'hC) && (bus_addr[11:8] != 4'h0);
   assign slot_pg = in_rom && !bus_addr[11];

   p_one_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({sel_internal, sel_float, sel_card}) <= 1);

   p_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !win_owned && slot_pg &&
       !(slot3_sw && bus_addr[10:8] == 3'd3))
      |=> (win_owned && win_slot == $past(bus_addr[10:8])));

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && win_owned && bus_addr != 16'hCFFF)
      |=> (win_owned && win_slot == $past(win_slot)));

   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr == 16'hCFFF) |=> !win_owned);

   p_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !win_owned && slot3_sw && bus_addr[15:8] == 8'hC3)
      |=> !win_owned);

   p_introm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && in_rom && int_sw) |-> sel_internal);

   p_wrdrop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we && in_rom)
      |-> (wr_discard && !sel_internal && !sel_float && sel_card == '0));

   p_stat_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_hit |-> (stat_data[6:0] == 7'd0));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> ($stable(win_owned) && $stable(int_sw) && $stable(slot3_sw)));

endmodule

bind cx_rom_window cxw_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_SLOTS (NUM_SLOTS)
) u_cxw_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_valid    (bus_valid),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .sel_internal (sel_internal),
   .sel_card     (sel_card),
   .sel_float    (sel_float),
   .wr_discard   (wr_discard),
   .stat_hit     (stat_hit),
   .stat_data    (stat_data),
   .int_sw       (int_sw),
   .slot3_sw     (slot3_sw),
   .win_owned    (win_owned),
   .win_slot     (win_slot)
);

// File: tb/cx_rom_window_bench.sv
`timescale 1ns/100ps
module cx_rom_window_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        sel_internal;
   logic [7:0]  sel_card;
   logic        sel_float;
   logic        wr_discard;
   logic        stat_hit;
   logic [7:0]  stat_data;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic       m_int = 1'b0;
   logic       m_s3  = 1'b0;
   logic       m_own = 1'b0;
   logic [2:0] m_slot = 3'd0;

   always #2.5 clk = ~clk;

   cx_rom_window u_cx_rom_window (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_valid    (bus_valid),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .sel_internal (sel_internal),
      .sel_card     (sel_card),
      .sel_float    (sel_float),
      .wr_discard   (wr_discard),
      .stat_hit     (stat_hit),
      .stat_data    (stat_data)
   );

   // one bus cycle: drive after falling edge, check 1 ns later, advance model at rising edge
   task automatic cyc(input logic v, input logic w, input logic [15:0] a, input string tag);
      logic       in_rom, rd;
      logic [3:0] pg;
      logic       e_int, e_flt, e_wd, e_sh;
      logic [7:0] e_card, e_sd;
      logic       n_int, n_s3, n_own;
      logic [2:0] n_slot;
      string      t;
      @(negedge clk);
      bus_valid = v; bus_we = w; bus_addr = a;
      #1;
      pg     = a[11:8];
      in_rom = (a[15:12] == 4'hC) && (pg != 4'h0);
      rd     = v && !w;
      e_int  = rd && in_rom && (m_int || (m_s3 && (pg == 4'd3 || pg >= 4'd8)));
      e_card = 8'h00;
      e_flt  = 1'b0;
      if (rd && in_rom && !e_int) begin
         if (pg < 4'd8)  e_card[pg[2:0]] = 1'b1;
         else if (m_own) e_card[m_slot] = 1'b1;
         else            e_flt = 1'b1;
      end
      e_wd = v && w && in_rom;
      e_sh = rd && (a == 16'hC015 || a == 16'hC017);
      e_sd = e_sh ? {(a == 16'hC015) ? m_int : m_s3, 7'd0} : 8'h00;
      t = tag;
      if (t == "") begin
         if (!v || !(in_rom || e_sh)) t = "R11";
         else if (e_wd)               t = "R9";
         else if (e_sh)               t = "R8";
         else if (m_int)              t = "R4";
         else if (e_int)              t = "R5";
         else                         t = "R6";
      end
      checks++;
      if ({sel_internal, sel_card, sel_float, wr_discard, stat_hit, stat_data} !==
          {e_int, e_card, e_flt, e_wd, e_sh, e_sd}) begin
         errors++;
         $display("FAIL %s addr=%h v=%0b we=%0b: got int=%0b card=%h flt=%0b wd=%0b sh=%0b sd=%h exp int=%0b card=%h flt=%0b wd=%0b sh=%0b sd=%h",
                  t, a, v, w, sel_internal, sel_card, sel_float, wr_discard, stat_hit, stat_data,
                  e_int, e_card, e_flt, e_wd, e_sh, e_sd);
      end
      n_int = m_int; n_s3 = m_s3; n_own = m_own; n_slot = m_slot;
      if (v) begin
         if (a == 16'hCFFF) n_own = 1'b0;
         else if (!m_own && in_rom && pg < 4'd8 && !(pg == 4'd3 && m_s3)) begin
            n_own = 1'b1; n_slot = pg[2:0];
         end
         if (w) begin
            if (a == 16'hC006) n_int = 1'b0;
            if (a == 16'hC007) n_int = 1'b1;
            if (a == 16'hC00A) n_s3 = 1'b0;
            if (a == 16'hC00B) n_s3 = 1'b1;
         end
      end
      @(posedge clk);
      m_int = n_int; m_s3 = n_s3; m_own = n_own; m_slot = n_slot;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_valid = 1'b0;
      @(posedge clk); @(posedge clk);
      m_int = 1'b0; m_s3 = 1'b0; m_own = 1'b0; m_slot = 3'd0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_sw(input logic i, input logic s);
      cyc(1'b1, 1'b1, i ? 16'hC007 : 16'hC006, "R7");
      cyc(1'b1, 1'b1, s ? 16'hC00B : 16'hC00A, "R7");
   endtask

   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R10: reset state
      cyc(1'b1, 1'b0, 16'hC015, "R10");
      cyc(1'b1, 1'b0, 16'hC017, "R10");
      cyc(1'b1, 1'b0, 16'hC900, "R10");

      // R7 / R8: switch writes and status reads
      cyc(1'b1, 1'b1, 16'hC007, "R7");
      cyc(1'b1, 1'b0, 16'hC015, "R7");
      cyc(1'b1, 1'b1, 16'hC00B, "R7");
      cyc(1'b1, 1'b0, 16'hC017, "R8");
      cyc(1'b1, 1'b1, 16'hC006, "R7");
      cyc(1'b1, 1'b0, 16'hC015, "R8");
      cyc(1'b1, 1'b1, 16'hC00A, "R7");
      cyc(1'b1, 1'b0, 16'hC017, "R8");
      cyc(1'b1, 1'b0, 16'hC016, "R8");

      // R4 / R5 / R6: every page under every switch pair and window state
      for (int sw = 0; sw < 4; sw++) begin
         for (int ws = 0; ws < 3; ws++) begin
            set_sw(sw[1], sw[0]);
            cyc(1'b1, 1'b0, 16'hCFFF, "R2");
            if (ws == 1) cyc(1'b1, 1'b0, 16'hC600, "R1");
            if (ws == 2) cyc(1'b1, 1'b0, 16'hC300, "R3");
            for (int p = 15; p >= 1; p--)
               cyc(1'b1, 1'b0, {4'hC, 4'(p), 8'h20}, "");
         end
      end
      set_sw(1'b0, 1'b0);

      // R1: first claim wins, later slot pages leave the owner alone
      cyc(1'b1, 1'b0, 16'hCFFF, "R2");
      cyc(1'b1, 1'b0, 16'hC500, "R1");
      cyc(1'b1, 1'b0, 16'hC200, "R1");
      cyc(1'b1, 1'b1, 16'hC700, "R1");
      cyc(1'b1, 1'b0, 16'hC900, "R1");
      cyc(1'b1, 1'b0, 16'hCFFE, "R1");
      // R2: release then float
      cyc(1'b1, 1'b0, 16'hCFFF, "R2");
      cyc(1'b1, 1'b0, 16'hCA00, "R2");
      // R1: a write claims too
      cyc(1'b1, 1'b1, 16'hC4FF, "R1");
      cyc(1'b1, 1'b0, 16'hC800, "R1");
      // R2: a write to CFFF releases
      cyc(1'b1, 1'b1, 16'hCFFF, "R2");
      cyc(1'b1, 1'b0, 16'hC800, "R2");

      // R3: guarded slot 3 page does not claim
      set_sw(1'b0, 1'b1);
      cyc(1'b1, 1'b0, 16'hC310, "R3");
      set_sw(1'b0, 1'b0);
      cyc(1'b1, 1'b0, 16'hCC00, "R3");
      cyc(1'b1, 1'b0, 16'hC310, "R3");
      cyc(1'b1, 1'b0, 16'hCC00, "R3");

      // R9: writes across the region
      for (int p = 1; p < 16; p++)
         cyc(1'b1, 1'b1, {4'hC, 4'(p), 8'h40}, "R9");
      cyc(1'b1, 1'b0, 16'hCD00, "R9");

      // R11: outside region and idle cycles
      cyc(1'b1, 1'b0, 16'hCFFF, "R2");
      for (int n = 0; n < 16; n++)
         if (n != 12) cyc(1'b1, 1'b0, {4'(n), 4'h1, 8'h00}, "R11");
      cyc(1'b1, 1'b0, 16'hC0FF, "R11");
      cyc(1'b0, 1'b0, 16'hC200, "R11");
      cyc(1'b0, 1'b1, 16'hC007, "R11");
      cyc(1'b1, 1'b0, 16'hC800, "R11");
      cyc(1'b1, 1'b0, 16'hC015, "R11");

      // R10: reset in the middle of use
      set_sw(1'b1, 1'b1);
      cyc(1'b1, 1'b0, 16'hC100, "R10");
      do_reset();
      cyc(1'b1, 1'b0, 16'hC015, "R10");
      cyc(1'b1, 1'b0, 16'hC017, "R10");
      cyc(1'b1, 1'b0, 16'hC800, "R10");

      cyc(1'b0, 1'b0, 16'h0000, "R11");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule